// File: doc/BRIEF.md
# Overload Timer with Double-Hiccup Restart

This block sits in the fault path of a current-mode switching controller. It measures how long the primary peak-current limit has been hit without a break. When that time reaches a programmed limit it stops the gate drive and lets the supply rail collapse. If the feedback loop also reports a hard short, the limit is one quarter of the programmed value.

After a fault, the block restarts on every second rise of the supply to its start threshold only. The skipped cycle halves the duty of the fault bursts. A brown-out recovery (line status going from bad to good) cancels the pending skip, so the controller restarts at the next supply peak. Every restart raises a one-cycle soft-start request. An option bit makes a short-circuit timeout latch the controller off instead of auto-recovering.

The supply rail is abstracted to two one-cycle events: one for the rail falling to its minimum and one for the rail reaching the start level. The timer counts clock cycles.

Top module: `hiccup_fault_timer`

## Requirements
- R1: After reset, drv_en, ss_req and latch_req are 0. The first start_evt seen with bo_ok high starts the converter at once, with no skipped cycle: drv_en goes to 1 and ss_req pulses.
- R2: While running, the timer advances once per clock with peak_hit high and returns to zero on any clock with peak_hit low. The timer expires, and drv_en falls, on the FULL_CYC-th consecutive clock with peak_hit high.
- R3: With short_hit high together with peak_hit, the expiry comes on the (FULL_CYC/4)-th consecutive clock.
- R4: If short_hit rises part way through a count, the elapsed count is compared with the short limit. A count already at or past FULL_CYC/4 - 1 expires on that same clock.
- R5: After an auto-recovery expiry, drv_en stays 0. start_evt is ignored until uv_evt reports that the rail has collapsed.
- R6: After the collapse, the first start_evt is skipped with no drive and no soft-start. The second start_evt restarts the drive and pulses ss_req.
- R7: A rising edge on bo_ok clears a pending skipped cycle, so the next start_evt restarts at once.
- R8: While bo_ok is low, drv_en is 0 and start_evt does not start the converter.
- R9: With latch_on_short high, a short-circuit expiry sets latch_req. latch_req then stays 1 and drv_en stays 0 whatever the inputs do, until reset.
- R10: A uv_evt while running stops the drive without arming a skip, so the next start_evt restarts at once.
- R11: ss_req is high for exactly one clock per restart, and only on the clock at which drive begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| peak_hit | input | 1 | Peak-current limit reached this cycle |
| short_hit | input | 1 | Feedback above the short-circuit threshold |
| uv_evt | input | 1 | One-cycle event: supply fell to its minimum |
| start_evt | input | 1 | One-cycle event: supply reached the start level |
| bo_ok | input | 1 | Line voltage acceptable (1) or in brown-out (0) |
| latch_on_short | input | 1 | 1: latch off on a short-circuit timeout; 0: auto-recover |
| drv_en | output | 1 | Gate drive enable |
| ss_req | output | 1 | One-cycle soft-start request on each restart |
| latch_req | output | 1 | Request to latch the controller off |

## Verification
The bench builds the block with FULL_CYC = 16, which gives a short limit of 4 clocks. With these values, full overload expiry, quarter-time short expiry and a switch to the short limit mid-count all occur within a few dozen cycles. Each path can then be checked clock by clock, with the expiry cycle and the cycle before it both observed. The short window also lets the bench run the complete collapse, skip and restart sequence several times. These runs cover the brown-out cancel, a brown-out blocking a start, and the latch option.

// File: rtl/hiccup_fault_timer.sv
module hiccup_fault_timer #(
  parameter int FULL_CYC = 50000,
  localparam int CNT_W = $clog2(FULL_CYC + 1),
  localparam int SHORT_CYC = FULL_CYC / 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic peak_hit,
  input  logic short_hit,
  input  logic uv_evt,
  input  logic start_evt,
  input  logic bo_ok,
  input  logic latch_on_short,
  output logic drv_en,
  output logic ss_req,
  output logic latch_req
);

  typedef enum logic [1:0] {S_WAIT, S_RUN, S_OFF, S_LATCH} state_t;

  state_t st;
  logic [CNT_W-1:0] cnt;
  logic skip, bo_q;

  wire bo_rise = bo_ok && !bo_q;
  wire [CNT_W-1:0] lim_m1 = short_hit ? CNT_W'(SHORT_CYC - 1) : CNT_W'(FULL_CYC - 1);
  wire expire = peak_hit && (cnt >= lim_m1);

  assign drv_en    = (st == S_RUN) && bo_ok;
  assign latch_req = (st == S_LATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_WAIT;
      cnt    <= '0;
      skip   <= 1'b0;
      bo_q   <= 1'b0;
      ss_req <= 1'b0;
    end else begin
      bo_q   <= bo_ok;
      ss_req <= 1'b0;
      if (bo_rise) skip <= 1'b0;
      case (st)
        S_RUN: begin
          if (expire) begin
            cnt <= '0;
            if (short_hit && latch_on_short) st <= S_LATCH;
            else begin
              st   <= S_OFF;
              skip <= 1'b1;
            end
          end else if (uv_evt) begin
            st  <= S_WAIT;
            cnt <= '0;
          end else begin
            cnt <= peak_hit ? cnt + 1'b1 : '0;
          end
        end
        S_OFF: if (uv_evt) st <= S_WAIT;
        S_WAIT: begin
          if (start_evt && bo_ok) begin
            if (skip && !bo_rise) skip <= 1'b0;
            else begin
              st     <= S_RUN;
              ss_req <= 1'b1;
            end
          end
        end
        default: st <= S_LATCH;
      endcase
    end
  end

  a_r11_ss_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ss_req |=> !ss_req);
  a_r11_ss_at_run: assert property (@(posedge clk) disable iff (!rst_n)
    ss_req |-> st == S_RUN);
  a_r9_latch_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    latch_req |=> latch_req);
  a_r9_latch_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    latch_req |-> !drv_en);
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(FULL_CYC));
  a_r5_off_until_uv: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OFF && !uv_evt) |=> st == S_OFF);
  a_r8_bo_low_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !bo_ok |-> !drv_en);

endmodule

// File: tb/sim_hiccup_fault_timer.sv
module sim_hiccup_fault_timer;
  localparam int FULL = 16;
  localparam int SHRT = FULL / 4;

  logic clk = 0, rst_n = 0;
  logic peak_hit = 0, short_hit = 0, uv_evt = 0, start_evt = 0, bo_ok = 1, latch_on_short = 0;
  logic drv_en, ss_req, latch_req;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct {
    logic d, s, l;
    string tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  hiccup_fault_timer #(.FULL_CYC(FULL)) u0 (
    .clk(clk), .rst_n(rst_n), .peak_hit(peak_hit), .short_hit(short_hit),
    .uv_evt(uv_evt), .start_evt(start_evt), .bo_ok(bo_ok),
    .latch_on_short(latch_on_short), .drv_en(drv_en), .ss_req(ss_req),
    .latch_req(latch_req)
  );

  task automatic cyc(input logic ph, sh, uv, st, bo, ed, es, el, input string tag);
    exp_t e;
    @(negedge clk);
    peak_hit = ph; short_hit = sh; uv_evt = uv; start_evt = st; bo_ok = bo;
    @(posedge clk);
    e.d = ed; e.s = es; e.l = el; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if ({drv_en, ss_req, latch_req} !== {e.d, e.s, e.l}) begin
          n_fail++;
          $display("FAIL %s: got drv/ss/latch=%b%b%b expected %b%b%b",
                   e.tag, drv_en, ss_req, latch_req, e.d, e.s, e.l);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if ({drv_en, ss_req, latch_req} !== 3'b000) begin
      n_fail++;
      $display("FAIL R1 reset: got %b%b%b expected 000", drv_en, ss_req, latch_req);
    end
    rst_n = 1;
    // R1: first start is immediate
    cyc(0,0,0,1,1, 1,1,0, "R1 first start");
    cyc(0,0,0,0,1, 1,0,0, "R11 ss one cycle");
    // R2: a gap clears the count
    for (int i = 0; i < FULL - 1; i++) cyc(1,0,0,0,1, 1,0,0, "R2 counting");
    cyc(0,0,0,0,1, 1,0,0, "R2 gap");
    for (int i = 0; i < FULL - 1; i++) cyc(1,0,0,0,1, 1,0,0, "R2 recount");
    cyc(1,0,0,0,1, 0,0,0, "R2 full expiry");
    // R5, R6
    cyc(0,0,0,1,1, 0,0,0, "R5 start ignored before collapse");
    cyc(0,0,1,0,1, 0,0,0, "R5 collapse");
    cyc(0,0,0,1,1, 0,0,0, "R6 first start skipped");
    cyc(0,0,1,0,1, 0,0,0, "R6 collapse again");
    cyc(0,0,0,1,1, 1,1,0, "R6 second start restarts");
    cyc(0,0,0,0,1, 1,0,0, "R11 ss drops");
    // R3: quarter limit
    for (int i = 0; i < SHRT - 1; i++) cyc(1,1,0,0,1, 1,0,0, "R3 short counting");
    cyc(1,1,0,0,1, 0,0,0, "R3 short expiry");
    cyc(0,0,1,0,1, 0,0,0, "R3 collapse");
    cyc(0,0,0,1,1, 0,0,0, "R6 skip after short");
    cyc(0,0,1,0,1, 0,0,0, "R6 collapse");
    cyc(0,0,0,1,1, 1,1,0, "R6 restart after short");
    // R4: switch to short mid-count
    for (int i = 0; i < 10; i++) cyc(1,0,0,0,1, 1,0,0, "R4 overload counting");
    cyc(1,1,0,0,1, 0,0,0, "R4 mid-count short expiry");
    // R7: brown-out recovery cancels skip
    cyc(0,0,0,0,0, 0,0,0, "R7 brown-out");
    cyc(0,0,1,0,0, 0,0,0, "R7 collapse");
    cyc(0,0,0,0,1, 0,0,0, "R7 line back");
    cyc(0,0,0,1,1, 1,1,0, "R7 immediate restart");
    // R8: brown-out gates drive and blocks start
    cyc(0,0,0,0,0, 0,0,0, "R8 drive gated");
    cyc(0,0,0,0,1, 1,0,0, "R8 drive back");
    cyc(0,0,1,0,1, 0,0,0, "R10 uv while running");
    cyc(0,0,0,1,0, 0,0,0, "R8 start blocked");
    cyc(0,0,0,0,1, 0,0,0, "R8 line back");
    cyc(0,0,0,1,1, 1,1,0, "R10 immediate restart");
    // R9: latch option
    latch_on_short = 1;
    for (int i = 0; i < SHRT - 1; i++) cyc(1,1,0,0,1, 1,0,0, "R9 short counting");
    cyc(1,1,0,0,1, 0,0,1, "R9 latch set");
    cyc(0,0,1,0,1, 0,0,1, "R9 latched uv");
    cyc(0,0,0,1,1, 0,0,1, "R9 latched start");
    cyc(0,0,0,0,0, 0,0,1, "R9 latched bo low");
    cyc(0,0,0,1,1, 0,0,1, "R9 latched bo rise start");
    repeat (3) @(posedge clk);
    #6;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule